// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. A client hands it a start address, a byte count and a polarity-free choice of completion method, then streams the bytes over a valid/ready channel. The sequencer turns that burst into chip-enable, write-enable, output-enable, address and data pin activity. It groups consecutive bytes into page loads and keeps every write-enable falling edge close enough to the previous one that the device keeps loading. After a load it reads back status until the device reports that its internal programming has finished.

A load ends for three reasons. The burst reaches a page boundary, the burst runs out of bytes, or the byte stream stalls long enough that the next write strobe would arrive too late. After each load the sequencer releases the data bus and issues status reads at the last written address. It uses one of two completion tests. In data polling, bit 7 of the read value must match the true bit 7 of the last byte written. In toggle polling, bit 6 must read the same on two reads in a row. If programming never completes, a poll timeout ends the burst with an error flag.

Top module: `eeprom_wr_seq`

## Requirements
- R1: While write enable is low, chip enable is low, output enable is high and the data bus is driven. Write enable stays low for exactly WE_CYC cycles, and address and data stay unchanged through the cycle in which write enable returns high.
- R2: The bytes of a burst are written, in stream order, to consecutive addresses starting at the request address.
- R3: All write strobes of one page load share address bits AW-1 down to PAGE_BITS. A burst that crosses a page boundary ends the load, waits for completion, then starts a new load.
- R4: Within one load, successive write-enable falling edges are at most GAP_MAX cycles apart. If the next byte is not available in time, the load is closed and polled, and no write strobe occurs while the device is programming.
- R5: During a status read, chip enable and output enable are low, write enable is high, the data bus is released and the address is the last written address. The data bus is never driven while output enable is low.
- R6: With req_mode = 0 (data polling), a load is complete when the sampled bit 7 equals bit 7 of the last byte written. Done is never signalled while the device is still loading or programming.
- R7: With req_mode = 1 (toggle polling), a load is complete when two consecutive status reads return the same bit 6. Done is never signalled while the device is still loading or programming.
- R8: If completion is not seen within POLL_TO cycles of the start of polling, the burst ends with done and err = 1.
- R9: req_ready is high only when idle. busy is high from the cycle after a non-empty request is accepted until done. done is a one-cycle pulse. err is valid with done and holds until the next request is accepted. After reset the sequencer is idle with all memory strobes high and the bus released.
- R10: A request with req_len = 0 produces done with err = 0 and no chip-enable activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_addr | input | AW | Start address of the burst |
| req_len | input | LW | Number of bytes in the burst |
| req_mode | input | 1 | 0 = data polling, 1 = toggle polling |
| data_valid | input | 1 | Stream byte valid |
| data_ready | output | 1 | Stream byte taken this cycle |
| data_in | input | 8 | Stream byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data read from memory |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| err | output | 1 | Poll timeout flag for the last burst |

## Verification
The hardest case to reach from the ports is a load closed by a starving byte stream rather than by a page boundary. To reach it, the bench holds data_valid low for longer than the strobe window in the middle of a burst. This forces a poll between two bytes that share a page, and the device model counts the extra programming cycle. The timeout path is also hard to reach, because a correct device always finishes. The bench device model therefore has a stuck mode that never leaves programming, and is then cleared so that the next burst can show that err has been cleared.

// File: rtl/eew_pkg.sv
package eew_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SETUP,
      ST_WEL,
      ST_HOLD,
      ST_GAP,
      ST_READ,
      ST_DONE
   } seq_st_t;

   localparam logic MODE_DATA   = 1'b0;
   localparam logic MODE_TOGGLE = 1'b1;
endpackage

// File: rtl/eew_win_timer.sv
module eew_win_timer #(
   parameter int GAP_MAX = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic page_open,
   output logic load_ok
);
   localparam int GW = $clog2(GAP_MAX + 2);

   logic [GW-1:0] gap_q;

   // restart is high the cycle before a write strobe falls, so gap_q reads 0 on the fall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_q <= '0;
      else if (restart)                   gap_q <= '0;
      else if (gap_q != GW'(GAP_MAX))     gap_q <= gap_q + 1'b1;
   end

   // a byte accepted now falls two cycles later
   assign load_ok = (gap_q <= GW'(GAP_MAX - 2));

   p_gap_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart && page_open |-> gap_q < GW'(GAP_MAX));
endmodule

// File: rtl/eew_poll_eval.sv
module eew_poll_eval #(
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic mode,
   input  logic smp7,
   input  logic smp6,
   input  logic ref7,
   input  logic prev6,
   input  logic have_prev,
   output logic complete
);
   generate
      if (HAS_TOGGLE) begin : g_both
         always_comb begin
            if (mode == eew_pkg::MODE_TOGGLE) complete = have_prev && (smp6 == prev6);
            else                              complete = (smp7 == ref7);
         end
      end else begin : g_data_only
         logic unused_tog;
         assign unused_tog = mode ^ smp6 ^ prev6 ^ have_prev;
         assign complete   = (smp7 == ref7);
      end
   endgenerate
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
   import eew_pkg::*;
#(
   parameter int AW         = 17,
   parameter int LW         = 9,
   parameter int PAGE_BITS  = 8,
   parameter int WE_CYC     = 2,
   parameter int RD_CYC     = 2,
   parameter int GAP_MAX    = 16,
   parameter int POLL_TO    = 400000,
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          req_mode,
   input  logic          data_valid,
   output logic          data_ready,
   input  logic [7:0]    data_in,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [7:0]    mem_dq_in,
   output logic          busy,
   output logic          done,
   output logic          err
);
   localparam int CMAX  = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
   localparam int CW    = $clog2(CMAX + 1);
   localparam int PW    = $clog2(POLL_TO + 1);
   localparam int TAG_W = AW - PAGE_BITS;

   generate
      if (GAP_MAX < WE_CYC + 3) begin : g_bad_gap
         $error("GAP_MAX must exceed the write pulse by at least 3 cycles");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= AW) begin : g_bad_page
         $error("PAGE_BITS must lie between 1 and AW-1");
      end
      if (WE_CYC < 1 || RD_CYC < 1) begin : g_bad_cyc
         $error("strobe lengths must be at least one cycle");
      end
      if (POLL_TO < 2 * (RD_CYC + 1)) begin : g_bad_to
         $error("POLL_TO shorter than two status reads");
      end
   endgenerate

   seq_st_t        state_q;
   logic [AW-1:0]  addr_q, last_addr_q;
   logic [LW-1:0]  rem_q;
   logic [7:0]     data_q;
   logic [CW-1:0]  cnt_q;
   logic [PW-1:0]  poll_cnt_q;
   logic           mode_q, last_d7_q, prev6_q, have_prev_q, page_open_q, err_q;
   logic           load_ok, complete, read_end, tmo;

   eew_win_timer #(.GAP_MAX(GAP_MAX)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (state_q == ST_SETUP),
      .page_open (page_open_q),
      .load_ok   (load_ok)
   );

   eew_poll_eval #(.HAS_TOGGLE(HAS_TOGGLE)) u_eval (
      .mode      (mode_q),
      .smp7      (mem_dq_in[7]),
      .smp6      (mem_dq_in[6]),
      .ref7      (last_d7_q),
      .prev6     (prev6_q),
      .have_prev (have_prev_q),
      .complete  (complete)
   );

   assign read_end = (state_q == ST_READ) && (cnt_q == CW'(RD_CYC - 1));
   assign tmo      = (poll_cnt_q >= PW'(POLL_TO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         last_addr_q <= '0;
         rem_q       <= '0;
         data_q      <= '0;
         cnt_q       <= '0;
         poll_cnt_q  <= '0;
         mode_q      <= MODE_DATA;
         last_d7_q   <= 1'b0;
         prev6_q     <= 1'b0;
         have_prev_q <= 1'b0;
         page_open_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q      <= req_addr;
               rem_q       <= req_len;
               mode_q      <= req_mode;
               err_q       <= 1'b0;
               page_open_q <= 1'b0;
               state_q     <= (req_len == '0) ? ST_DONE : ST_FETCH;
            end
            ST_FETCH: begin
               if (page_open_q && !load_ok) begin
                  state_q     <= ST_GAP;
                  poll_cnt_q  <= '0;
                  have_prev_q <= 1'b0;
               end else if (data_valid) begin
                  data_q  <= data_in;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               cnt_q   <= '0;
               state_q <= ST_WEL;
            end
            ST_WEL: begin
               if (cnt_q == CW'(WE_CYC - 1)) state_q <= ST_HOLD;
               else                          cnt_q   <= cnt_q + 1'b1;
            end
            ST_HOLD: begin
               last_addr_q <= addr_q;
               last_d7_q   <= data_q[7];
               page_open_q <= 1'b1;
               rem_q       <= rem_q - 1'b1;
               addr_q      <= addr_q + 1'b1;
               if (rem_q == LW'(1) || (&addr_q[PAGE_BITS-1:0])) begin
                  state_q     <= ST_GAP;
                  poll_cnt_q  <= '0;
                  have_prev_q <= 1'b0;
               end else begin
                  state_q <= ST_FETCH;
               end
            end
            ST_GAP: begin
               poll_cnt_q <= poll_cnt_q + 1'b1;
               if (tmo) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  cnt_q   <= '0;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               poll_cnt_q <= poll_cnt_q + 1'b1;
               if (read_end && complete) begin
                  page_open_q <= 1'b0;
                  state_q     <= (rem_q == '0) ? ST_DONE : ST_FETCH;
               end else if (tmo) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else if (read_end) begin
                  have_prev_q <= 1'b1;
                  prev6_q     <= mem_dq_in[6];
                  state_q     <= ST_GAP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (state_q == ST_IDLE);
      data_ready = (state_q == ST_FETCH) && (!page_open_q || load_ok);
      mem_ce_n   = !(state_q inside {ST_SETUP, ST_WEL, ST_HOLD, ST_READ});
      mem_we_n   = (state_q != ST_WEL);
      mem_oe_n   = (state_q != ST_READ);
      mem_dq_oe  = (state_q inside {ST_SETUP, ST_WEL, ST_HOLD});
      mem_dq_out = data_q;
      mem_addr   = (state_q inside {ST_GAP, ST_READ}) ? last_addr_q : addr_q;
      busy       = !(state_q inside {ST_IDLE, ST_DONE});
      done       = (state_q == ST_DONE);
      err        = err_q;
   end

   // ---------------- assertions ----------------
   logic             we_d_q, chk_in_load_q, we_fall;
   logic [TAG_W-1:0] chk_tag_q;

   assign we_fall = we_d_q && !mem_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_d_q        <= 1'b1;
         chk_in_load_q <= 1'b0;
         chk_tag_q     <= '0;
      end else begin
         we_d_q <= mem_we_n;
         if (we_fall) begin
            chk_in_load_q <= 1'b1;
            if (!chk_in_load_q) chk_tag_q <= mem_addr[AW-1:PAGE_BITS];
         end else if ((state_q == ST_FETCH && !page_open_q) || state_q == ST_IDLE) begin
            chk_in_load_q <= 1'b0;
         end
      end
   end

   p_we_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n && mem_oe_n && mem_dq_oe);
   p_we_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> $stable(mem_dq_out) && $stable(mem_addr));
   p_page_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_fall && chk_in_load_q |-> mem_addr[AW-1:PAGE_BITS] == chk_tag_q);
   p_bus_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe && mem_we_n && !mem_ce_n);
   p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP || state_q == ST_READ) |-> poll_cnt_q < PW'(POLL_TO));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);
   p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy && !done);
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_len != '0 |=> busy);
endmodule

// File: tb/tb_eeprom_wr_seq.sv
module tb_eeprom_wr_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 17, LW = 9, PB = 4, WE_CYC = 2, RD_CYC = 2, GAP_MAX = 12;
   localparam int POLL_TO = 400, PROG_CYC = 60;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_mode = 1'b0, data_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [7:0] data_in = '0, rd_val = '0;
   logic req_ready, data_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done, err;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_dq_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_wr_seq #(.AW(AW), .LW(LW), .PAGE_BITS(PB), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
                   .GAP_MAX(GAP_MAX), .POLL_TO(POLL_TO), .HAS_TOGGLE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode),
      .data_valid(data_valid), .data_ready(data_ready), .data_in(data_in),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(rd_val),
      .busy(busy), .done(done), .err(err));

   int n_chk = 0, n_fail = 0;
   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // ---------------- behavioural device model ----------------
   logic [7:0] mem_m [int];
   logic [7:0] buf_m [int];
   int cyc = 0, last_fall = 0, we_low = 0, prog_left = 0, loads = 0, ce_falls = 0;
   bit loading = 0, tog = 0, last7 = 0, stuck = 0, prev_we = 1, prev_oe = 1, prev_ce = 1;
   int load_tag = 0, wr_addr = 0, last_wr = 0;
   // expected write order
   logic [7:0] bytes_q [$];
   int wi = 0, exp_a = 0;

   function automatic bit dev_busy();
      return loading || (prog_left > 0);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_ce && !mem_ce_n) ce_falls++;
         if (prev_we && !mem_we_n) begin
            chk(!mem_ce_n && mem_oe_n && mem_dq_oe, "R1 strobe pins", {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b011);
            chk(prog_left == 0, "R4 strobe while programming", prog_left, 0);
            if (loading) begin
               chk((mem_addr >> PB) == load_tag, "R3 page tag", int'(mem_addr >> PB), load_tag);
               chk(cyc - last_fall <= GAP_MAX, "R4 strobe gap", cyc - last_fall, GAP_MAX);
            end else begin
               loading  = 1;
               load_tag = int'(mem_addr >> PB);
               loads++;
            end
            last_fall = cyc;
            wr_addr   = int'(mem_addr);
            we_low    = 1;
         end else if (!mem_we_n) begin
            we_low++;
            chk(int'(mem_addr) == wr_addr, "R1 address stable", int'(mem_addr), wr_addr);
         end else if (!prev_we && mem_we_n) begin
            chk(we_low == WE_CYC, "R1 strobe width", we_low, WE_CYC);
            chk(mem_dq_oe && !mem_ce_n && int'(mem_addr) == wr_addr, "R1 hold", int'(mem_addr), wr_addr);
            buf_m[wr_addr] = mem_dq_out;
            last7   = mem_dq_out[7];
            last_wr = wr_addr;
            chk(wr_addr == exp_a, "R2 address order", wr_addr, exp_a);
            chk(wi < bytes_q.size() && mem_dq_out == bytes_q[wi], "R2 data order", mem_dq_out,
                (wi < bytes_q.size()) ? bytes_q[wi] : 0);
            wi++;
            exp_a = (exp_a + 1) & ((1 << AW) - 1);
         end
         if (prev_oe && !mem_oe_n) begin
            chk(!mem_dq_oe && mem_we_n && !mem_ce_n, "R5 read pins", {mem_dq_oe, mem_we_n, mem_ce_n}, 3'b010);
            chk(int'(mem_addr) == last_wr, "R5 read address", int'(mem_addr), last_wr);
            if (dev_busy()) begin
               tog    = ~tog;
               rd_val = {~last7, tog, 6'h15};
            end else begin
               rd_val = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'hFF;
            end
         end
         if (!mem_oe_n && mem_dq_oe) chk(1'b0, "R5 bus contention", 1, 0);
         if (loading && (cyc - last_fall > GAP_MAX)) begin
            loading   = 0;
            prog_left = stuck ? (1 << 30) : PROG_CYC;
         end else if (prog_left > 0) begin
            prog_left--;
            if (prog_left == 0) begin
               foreach (buf_m[a]) mem_m[a] = buf_m[a];
               buf_m.delete();
            end
         end
         prev_we = mem_we_n;
         prev_oe = mem_oe_n;
         prev_ce = mem_ce_n;
      end
   end

   // ---------------- byte stream driver ----------------
   bit hs = 0;
   int idx = 0, stall_idx = -1, stall_left = 0;
   always @(posedge clk) hs <= data_valid && data_ready;
   always @(negedge clk) begin
      if (hs) idx++;
      if (idx == stall_idx && stall_left > 0) begin
         stall_left--;
         data_valid = 1'b0;
      end else begin
         data_valid = (idx < bytes_q.size());
      end
      data_in = (idx < bytes_q.size()) ? bytes_q[idx] : 8'h00;
   end

   task automatic run_burst(input int addr, input int len, input bit mode, input int st_idx,
                            input int st_cyc, input int exp_loads, input bit exp_err, input string tag);
      int loads0, n, ce0;
      @(negedge clk);
      bytes_q.delete();
      for (int i = 0; i < len; i++) bytes_q.push_back(8'((addr + i) * 37 + 8'h5A + len));
      wi = 0; exp_a = addr; idx = 0; stall_idx = st_idx; stall_left = st_cyc;
      loads0 = loads; ce0 = ce_falls;
      req_addr = AW'(addr); req_len = LW'(len); req_mode = mode; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (len != 0) chk(busy && !req_ready, {"R9 busy after accept ", tag}, {busy, req_ready}, 2'b10);
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done, {"R9 done seen ", tag}, done, 1);
      chk(err == exp_err, {"R8 err flag ", tag}, err, exp_err);
      if (!exp_err) begin
         chk(!dev_busy(), {"R6 R7 device idle at done ", tag}, dev_busy(), 0);
         chk(loads - loads0 == exp_loads, {"R3 R4 load count ", tag}, loads - loads0, exp_loads);
         for (int i = 0; i < len; i++) begin
            int a;
            a = (addr + i) & ((1 << AW) - 1);
            chk(mem_m.exists(a) && mem_m[a] == bytes_q[i], {"R2 stored byte ", tag},
                mem_m.exists(a) ? mem_m[a] : -1, bytes_q[i]);
         end
      end
      if (len == 0) chk(ce_falls == ce0, "R10 no chip enable activity", ce_falls - ce0, 0);
      @(negedge clk);
      chk(!done && req_ready, {"R9 done is one pulse ", tag}, {done, req_ready}, 2'b01);
      chk(err == exp_err, {"R9 err holds ", tag}, err, exp_err);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !busy && !done && !err, "R9 reset state", {req_ready, busy, done, err}, 4'b1000);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9 reset pins",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      // R6: data polling inside one page
      run_burst(32'h103, 5, 1'b0, -1, 0, 1, 1'b0, "r6_data_single");
      // R7 + R3: toggle polling across two page boundaries
      run_burst(32'h00E, 20, 1'b1, -1, 0, 3, 1'b0, "r7_toggle_cross");
      // R3: data polling, one boundary
      run_burst(32'h238, 12, 1'b0, -1, 0, 2, 1'b0, "r3_data_cross");
      // R4: starving stream closes the load early
      run_burst(32'h300, 6, 1'b1, 3, 40, 2, 1'b0, "r4_stall_toggle");
      run_burst(32'h350, 6, 1'b0, 2, 30, 2, 1'b0, "r4_stall_data");
      // R10: empty burst
      run_burst(32'h360, 0, 1'b0, -1, 0, 0, 1'b0, "r10_empty");
      // R8: device never completes
      stuck = 1;
      run_burst(32'h400, 2, 1'b0, -1, 0, 1, 1'b1, "r8_timeout");
      @(negedge clk);
      stuck = 0; prog_left = 0; loading = 0; buf_m.delete();
      // R9: err cleared by the next accepted request
      run_burst(32'h410, 3, 1'b1, -1, 0, 1, 1'b0, "r9_err_clear");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule